// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

This block gathers service requests from a reset request, a software trap strobe and eleven numbered interrupt sources. Once per service slot it picks a single winner in a hard-wired order, registers a take strobe and the 16-bit address of the winner's vector, and, for a numbered source, raises an acknowledge pulse carrying the source index so that the source can drop its pending flag. Two of the numbered slots are reserved and can never win.

A two-bit mask level gates the numbered sources. Reset and the trap ignore it. The block also flags, for each of two low-power modes (a full stop mode and an active stop mode), whether a present request is allowed to end that mode. For the active stop mode, a build parameter selects between a permissive set of wake-up sources and a restricted one.

Top module: `irq_vec_arb`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, take_o, ack_o, wake_halt_o and wake_ahalt_o are 0 and vec_o and ack_id_o are 0. vec_o and ack_id_o read 0 in every cycle in which there is no take or no acknowledge.
- R2: A take for a reset request shows vector 16'hFFFE. A take for the trap shows 16'hFFFC. A take for numbered source n shows 16'hFFFA - 2*n, so source 10 maps to 16'hFFE6.
- R3: When requests are present together, a reset request wins first, the trap wins next, and then the numbered source with the smallest index wins.
- R4: Sources 0 and 6 are reserved. They are never taken or acknowledged and never raise a wake-up flag, whatever their request lines carry.
- R5: At mask level 3, numbered sources are not taken. Reset requests and the trap are still taken at that level.
- R6: take_o is asserted for single cycles only. The cycle after a take never holds another take. Requests that lose arbitration stay eligible and are taken in later slots.
- R7: ack_o pulses together with take_o exactly when a numbered source wins, and ack_id_o then equals that source's index. Takes for a reset request or for the trap leave ack_o at 0.
- R8: A trap strobe that cannot be served in its own cycle is held, and it is taken in a later slot.
- R9: One cycle after its inputs, wake_halt_o is 1 if a reset request is present or if any of sources 2, 3, 4, 5 or 7 is requesting. This holds at every mask level. Sources 1, 8, 9 and 10, as well as the trap, never raise it.
- R10: One cycle after its inputs, wake_ahalt_o follows a reset request or a request on source 1. With FLASH_BUILD=0, sources 2, 3, 4, 5 and 7 also raise it. With FLASH_BUILD=1, no other source raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| rst_req_i | input | 1 | Reset service request (level) |
| trap_i | input | 1 | Software trap strobe |
| irq_req_i | input | N_SRC | Request line per numbered source |
| mask_lvl_i | input | 2 | Global mask level; 3 blocks the numbered sources |
| take_o | output | 1 | One-cycle interrupt-take strobe |
| vec_o | output | VEC_W | Vector address of the winner |
| ack_o | output | 1 | Acknowledge pulse for a numbered source |
| ack_id_o | output | ID_W | Index of the acknowledged source |
| wake_halt_o | output | 1 | A request may end full stop mode |
| wake_ahalt_o | output | 1 | A request may end active stop mode |

## Verification
The hardest case to reach from the ports is a trap strobe that arrives in the cycle right after a take. In that cycle the arbiter cannot serve anything, so the trap must be held. A close second is a reset request, the trap and several sources all arriving together. The stimulus times the trap pulse to land in that quiet cycle. It also raises all contenders at once and lets the modelled sources drop their requests only on their own acknowledge, so that the full service order plays out slot by slot. The wake-up sets are checked with the mask at level 3, so that no take disturbs them, on one instance for each build option.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NSRC_DEF = 11;
  localparam logic [NSRC_DEF-1:0] RSVD_DEF     = 11'b000_0100_0001;
  localparam logic [NSRC_DEF-1:0] HALT_DEF     = 11'b000_1011_1100;
  localparam logic [NSRC_DEF-1:0] AH_ROM_DEF   = 11'b000_1011_1110;
  localparam logic [NSRC_DEF-1:0] AH_FLASH_DEF = 11'b000_0000_0010;
  localparam logic [1:0]          LVL_BLOCK    = 2'd3;

  typedef enum logic [1:0] {WIN_NONE, WIN_RST, WIN_TRAP, WIN_SRC} win_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N = 11,
  parameter logic [N-1:0] RSVD = '0
) (
  input  logic [N-1:0] req_i,
  input  logic [1:0]   mask_lvl_i,
  output logic [N-1:0] elig_o
);
  import irq_arb_pkg::*;
  logic open_w;
  assign open_w = (mask_lvl_i != LVL_BLOCK);
  assign elig_o = req_i & ~RSVD & {N{open_w}};
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 11,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  in_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_wake.sv
module irq_wake #(
  parameter int unsigned N = 11,
  parameter logic [N-1:0] HALT_SET  = '0,
  parameter logic [N-1:0] AHALT_SET = '0
) (
  input  logic         rst_req_i,
  input  logic [N-1:0] req_i,
  output logic         halt_hit_o,
  output logic         ahalt_hit_o
);
  assign halt_hit_o  = rst_req_i | (|(req_i & HALT_SET));
  assign ahalt_hit_o = rst_req_i | (|(req_i & AHALT_SET));
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC       = NSRC_DEF,
  parameter int unsigned VEC_W       = 16,
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
  parameter bit          FLASH_BUILD = 1'b0,
  parameter logic [N_SRC-1:0] RSVD     = RSVD_DEF,
  parameter logic [N_SRC-1:0] HALT_SET = HALT_DEF,
  parameter logic [N_SRC-1:0] AH_ROM   = AH_ROM_DEF,
  parameter logic [N_SRC-1:0] AH_FLASH = AH_FLASH_DEF,
  localparam int unsigned ID_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_req_i,
  input  logic             trap_i,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic [1:0]       mask_lvl_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ack_o,
  output logic [ID_W-1:0]  ack_id_o,
  output logic             wake_halt_o,
  output logic             wake_ahalt_o
);
  localparam logic [N_SRC-1:0] AH_SET = FLASH_BUILD ? AH_FLASH : AH_ROM;
  localparam logic [VEC_W-1:0] TRAP_OFS = VEC_W'(2);
  localparam logic [VEC_W-1:0] SRC_BASE = VEC_W'(4);

  logic [N_SRC-1:0] elig_w;
  logic             src_vld_w;
  logic [ID_W-1:0]  src_idx_w;
  logic             halt_hit_w, ahalt_hit_w;
  logic             trap_pend_q, trap_any_w;
  win_e             win_w;
  logic [VEC_W-1:0] vec_d, src_ofs_w;

  irq_gate #(.N(N_SRC), .RSVD(RSVD)) u_gate (
    .req_i(irq_req_i), .mask_lvl_i(mask_lvl_i), .elig_o(elig_w)
  );

  irq_prio_pick #(.N(N_SRC), .IW(ID_W)) u_pick (
    .in_i(elig_w), .vld_o(src_vld_w), .idx_o(src_idx_w)
  );

  irq_wake #(.N(N_SRC), .HALT_SET(HALT_SET & ~RSVD), .AHALT_SET(AH_SET & ~RSVD)) u_wake (
    .rst_req_i(rst_req_i), .req_i(irq_req_i),
    .halt_hit_o(halt_hit_w), .ahalt_hit_o(ahalt_hit_w)
  );

  assign trap_any_w = trap_pend_q | trap_i;
  assign src_ofs_w  = {{(VEC_W-ID_W-1){1'b0}}, src_idx_w, 1'b0} + SRC_BASE;

  // one quiet cycle after each take lets the served source drop its line
  always_comb begin
    if (take_o)          win_w = WIN_NONE;
    else if (rst_req_i)  win_w = WIN_RST;
    else if (trap_any_w) win_w = WIN_TRAP;
    else if (src_vld_w)  win_w = WIN_SRC;
    else                 win_w = WIN_NONE;
  end

  always_comb begin
    unique case (win_w)
      WIN_RST:  vec_d = VEC_TOP;
      WIN_TRAP: vec_d = VEC_TOP - TRAP_OFS;
      WIN_SRC:  vec_d = VEC_TOP - src_ofs_w;
      default:  vec_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o       <= 1'b0;
      vec_o        <= '0;
      ack_o        <= 1'b0;
      ack_id_o     <= '0;
      trap_pend_q  <= 1'b0;
      wake_halt_o  <= 1'b0;
      wake_ahalt_o <= 1'b0;
    end else begin
      take_o       <= (win_w != WIN_NONE);
      vec_o        <= vec_d;
      ack_o        <= (win_w == WIN_SRC);
      ack_id_o     <= (win_w == WIN_SRC) ? src_idx_w : '0;
      trap_pend_q  <= trap_any_w && (win_w != WIN_TRAP);
      wake_halt_o  <= halt_hit_w;
      wake_ahalt_o <= ahalt_hit_w;
    end
  end

  AST_TAKE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R6
  AST_ACK_IN_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> take_o); // R7
  AST_NO_RSVD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !RSVD[ack_id_o]); // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(mask_lvl_i) != LVL_BLOCK); // R5
  AST_RST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_i && !take_o) |=> (take_o && vec_o == VEC_TOP && !ack_o)); // R3
  AST_TRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && take_o) |=> trap_pend_q); // R8
endmodule

// File: tb/irq_vec_arb_tb_top.sv
module irq_vec_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic trap = 1'b0;
  logic [N-1:0] req = '0;
  logic [1:0] mask = 2'd0;

  logic take, ack, wh, wah, take_f, ack_f, wh_f, wah_f;
  logic [15:0] vec, vec_f;
  logic [3:0] id, id_f;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .trap_i(trap),
    .irq_req_i(req), .mask_lvl_i(mask), .take_o(take), .vec_o(vec),
    .ack_o(ack), .ack_id_o(id), .wake_halt_o(wh), .wake_ahalt_o(wah)
  );

  irq_vec_arb #(.FLASH_BUILD(1'b1)) dut_flash_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .trap_i(trap),
    .irq_req_i(req), .mask_lvl_i(mask), .take_o(take_f), .vec_o(vec_f),
    .ack_o(ack_f), .ack_id_o(id_f), .wake_halt_o(wh_f), .wake_ahalt_o(wah_f)
  );

  typedef struct {
    bit take; logic [15:0] vec; bit ack; logic [3:0] id;
    bit wh; bit wah; bit wahf; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit m_prev_take = 0;
  bit m_tpend = 0;

  function automatic bit halt_src(int n);
    return n inside {2, 3, 4, 5, 7};
  endfunction
  function automatic bit ahalt_rom_src(int n);
    return n inside {1, 2, 3, 4, 5, 7};
  endfunction

  task automatic step(string tag);
    exp_t e;
    bit tany;
    e.take = 0; e.vec = '0; e.ack = 0; e.id = '0; e.tag = tag;
    e.wh = rst_req; e.wah = rst_req; e.wahf = rst_req | req[1];
    for (int n = 0; n < N; n++) begin
      if (req[n] && halt_src(n)) e.wh = 1;
      if (req[n] && ahalt_rom_src(n)) e.wah = 1;
    end
    tany = m_tpend | trap;
    m_tpend = tany;
    if (!m_prev_take) begin
      if (rst_req) begin
        e.take = 1; e.vec = 16'hFFFE;
      end else if (tany) begin
        e.take = 1; e.vec = 16'hFFFC; m_tpend = 0;
      end else if (mask != 2'd3) begin
        for (int n = N - 1; n >= 1; n--) begin
          if (req[n] && n != 6) begin
            e.take = 1; e.ack = 1; e.id = 4'(n); e.vec = 16'(16'hFFFA - 2*n);
          end
        end
      end
    end
    m_prev_take = e.take;
    q.push_back(e);
    @(negedge clk);
    trap = 0;
    if (e.ack) req[e.id] = 0;
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (take !== e.take || vec !== e.vec || ack !== e.ack || id !== e.id ||
            wh !== e.wh || wah !== e.wah || wah_f !== e.wahf) begin
          errors++;
          $display("FAIL %s: act take=%b vec=%h ack=%b id=%0d wh=%b wah=%b wahf=%b exp take=%b vec=%h ack=%b id=%0d wh=%b wah=%b wahf=%b",
                   e.tag, take, vec, ack, id, wh, wah, wah_f,
                   e.take, e.vec, e.ack, e.id, e.wh, e.wah, e.wahf);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: act=expired exp=done");
    finish_run();
  end

  initial begin
    // R1: outputs held at zero while reset is applied, even with requests present
    rst_req = 1; req = 11'h7FF; trap = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (take || vec != 0 || ack || id != 0 || wh || wah || wah_f) begin
      errors++;
      $display("FAIL R1 reset: act take=%b vec=%h ack=%b wh=%b wah=%b exp all 0", take, vec, ack, wh, wah);
    end
    rst_req = 0; req = '0; trap = 0;
    @(negedge clk);
    rst_n = 1;
    step("R1 idle after reset");

    // R2: every numbered source alone, then a quiet gap cycle (R6)
    for (int n = 1; n < N; n++) begin
      if (n == 6) continue;
      req[n] = 1;
      step("R2 vector per source");
      step("R6 gap after take");
    end

    // R4: reserved slots driven
    req[0] = 1; req[6] = 1;
    step("R4 reserved ignored");
    step("R4 reserved ignored again");
    req = '0;
    step("R4 cleared");

    // R3 R7: all contenders at once
    rst_req = 1; trap = 1;
    req[10] = 1; req[8] = 1; req[3] = 1; req[1] = 1;
    step("R3 reset first");
    rst_req = 0;
    step("R6 gap");
    step("R3 trap second R7 no ack");
    step("R6 gap");
    for (int k = 0; k < 4; k++) begin
      step("R3 source order R7 ack id");
      step("R6 gap");
    end
    step("R3 idle");

    // R5: mask level 3
    mask = 2'd3; req[2] = 1;
    step("R5 masked source");
    step("R5 masked source held");
    trap = 1;
    step("R5 trap under mask");
    step("R6 gap");
    rst_req = 1;
    step("R5 reset under mask");
    rst_req = 0;
    step("R6 gap");
    mask = 2'd1;
    step("R5 unmasked source taken");
    step("R6 gap");

    // R8: trap in the quiet cycle is held
    req[5] = 1;
    step("R8 source take");
    trap = 1;
    step("R8 trap during gap");
    step("R8 held trap taken");
    step("R8 gap");

    // R9 R10: wake sets, masked so nothing is taken
    mask = 2'd3;
    for (int n = 0; n < N; n++) begin
      req = '0; req[n] = 1;
      step("R9 R10 wake per source");
    end
    req = '0; trap = 1;
    step("R9 trap no wake");
    rst_req = 1;
    step("R10 reset wakes");
    rst_req = 0; mask = 2'd0;
    step("R9 idle");
    step("R9 idle");

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule